// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Unit

This block sits beside a position counter and records what the counter has signalled. Four single-cycle event strobes (carry out of the top of the range, borrow below zero, count equal to the preset value, and an index mark) each set their own sticky latch. A status byte combines those latches with live views of the count-enable and direction inputs, a sign input, and a power-loss flag. That flag is raised by reset and cleared by the first status read.

A single read-and-clear strobe captures the status byte into the `status_byte` output register. In the same clock edge it clears every latch and the power-loss flag. An event that arrives in the cycle of the read is not lost: it sets its latch after the clear. Each source has an interrupt enable. The active-low `irq_n` output is pulled low while any enabled latch is set, and it stays low until a read clears it.

The power-loss flag is kept by a two-state machine. `PL_PENDING` is entered at reset and drives the flag to 1. The transition `READ_SEEN` (a read-and-clear strobe while in `PL_PENDING`) moves to `PL_CLEARED`, where the flag is 0. No transition leaves `PL_CLEARED`, so only a reset can return the machine to `PL_PENDING`.

Top module: `stat_irq_unit`

## Requirements
- R1: A pulse on `carry_evt`, `borrow_evt`, `cmp_evt` or `idx_evt` sets its own sticky latch. The latch stays set until a read and appears in the status byte at bit 7, 6, 5 and 4 respectively.
- R2: Status bit 3 shows `cnt_en`, bit 1 shows `dir_up` and bit 0 shows `sign_in`. Each is sampled at the edge where the read is taken.
- R3: Status bit 2 (power-loss) is 1 in every read taken since reset until the first read has been taken, and 0 in every later read.
- R4: When `rd_clr` is high at a clock edge, `status_byte` holds the status as it was before that edge, from the next cycle on. All four latches are cleared at that same edge.
- R5: `irq_n` goes low one cycle after a latch whose enable is set becomes set. It stays low until the read that clears that latch, and it is high in the cycle after that read when no event came with the read.
- R6: Interrupt enables reset to 0 and are loaded from `en_wdata` when `en_wr` is high (bit 3 carry, bit 2 borrow, bit 1 compare, bit 0 index). A latch whose enable is 0 still latches but leaves `irq_n` high.
- R7: An event in the same cycle as `rd_clr` is not in that read's byte, but its latch is set after the read and shows in the next read.
- R8: Several latches may be set at once, and one read returns all of them together.
- R9: After reset `status_byte` is 0x00 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_evt | input | 1 | Overflow event strobe |
| borrow_evt | input | 1 | Underflow event strobe |
| cmp_evt | input | 1 | Count-equals-preset event strobe |
| idx_evt | input | 1 | Index mark event strobe |
| cnt_en | input | 1 | Live count-enable level |
| dir_up | input | 1 | Live direction level, 1 = up |
| sign_in | input | 1 | Live sign level |
| en_wr | input | 1 | Load strobe for interrupt enables |
| en_wdata | input | 4 | Interrupt enable values |
| rd_clr | input | 1 | Read-and-clear strobe |
| status_byte | output | 8 | Byte captured by the last read |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
The latches and the read register each sit one register from the inputs. A strobe driven in one cycle is therefore visible on `irq_n` or `status_byte` after exactly one rising edge. The bench drives every input on the falling edge and samples on the following falling edge, so every check lands one cycle after its stimulus. The persistence checks for `irq_n` wait several further cycles before sampling again. The same-cycle case drives an event together with `rd_clr`: the first read byte is checked without the event's bit, and a second read is checked with it.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int NUM_SRC = 4;
    localparam int STAT_W  = 8;
    // source index inside event and enable vectors
    localparam int SRC_CARRY  = 3;
    localparam int SRC_BORROW = 2;
    localparam int SRC_CMP    = 1;
    localparam int SRC_IDX    = 0;

    typedef enum logic [0:0] {
        PL_PENDING = 1'b0,
        PL_CLEARED = 1'b1
    } pl_state_t;
endpackage

// File: rtl/sticky_latch.sv
module sticky_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // set wins over clear so a coincident event is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o); // R1
    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o); // R1
    AST_LATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o); // R4
endmodule

// File: rtl/pl_fsm.sv
module pl_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic pwr_loss_o
);
    pl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PL_PENDING;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PL_PENDING: if (rd_i) state_d = PL_CLEARED; // READ_SEEN
            PL_CLEARED: state_d = PL_CLEARED;
            default:    state_d = PL_PENDING;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PL_PENDING: pwr_loss_o = 1'b1;
            PL_CLEARED: pwr_loss_o = 1'b0;
            default:    pwr_loss_o = 1'b1;
        endcase
    end

    AST_PL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> !pwr_loss_o); // R3
    AST_PL_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_loss_o |=> !pwr_loss_o); // R3
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int N = 4
) (
    input  logic [N-1:0] lat_i,
    input  logic [N-1:0] en_i,
    output logic         irq_n_o
);
    logic [N-1:0] hit;
    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = lat_i[g] & en_i[g];
    end
    assign irq_n_o = ~(|hit);

    always_comb begin
        AST_IRQ_QUIET: assert (!(en_i == '0 && irq_n_o == 1'b0)); // R6
    end
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
    import stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carry_evt,
    input  logic       borrow_evt,
    input  logic       cmp_evt,
    input  logic       idx_evt,
    input  logic       cnt_en,
    input  logic       dir_up,
    input  logic       sign_in,
    input  logic       en_wr,
    input  logic [3:0] en_wdata,
    input  logic       rd_clr,
    output logic [7:0] status_byte,
    output logic       irq_n
);
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] lat_q;
    logic [NUM_SRC-1:0] en_q;
    logic               pwr_loss;
    logic [STAT_W-1:0]  status_live;

    assign evt_vec[SRC_CARRY]  = carry_evt;
    assign evt_vec[SRC_BORROW] = borrow_evt;
    assign evt_vec[SRC_CMP]    = cmp_evt;
    assign evt_vec[SRC_IDX]    = idx_evt;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sticky_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_vec[s]),
            .clr_i (rd_clr),
            .q_o   (lat_q[s])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    pl_fsm u_pl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_clr),
        .pwr_loss_o (pwr_loss)
    );

    assign status_live = {lat_q, cnt_en, pwr_loss, dir_up, sign_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status_byte <= '0;
        else if (rd_clr) status_byte <= status_live;
    end

    irq_combiner #(.N(NUM_SRC)) u_irq (
        .lat_i   (lat_q),
        .en_i    (en_q),
        .irq_n_o (irq_n)
    );

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt_vec == '0) |=> irq_n); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_clr && !en_wr) |=> !irq_n); // R5
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> $stable(status_byte)); // R4
endmodule

// File: tb/tb_stat_irq_unit.sv
module tb_stat_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carry_evt = 0, borrow_evt = 0, cmp_evt = 0, idx_evt = 0;
    logic       cnt_en = 0, dir_up = 0, sign_in = 0;
    logic       en_wr = 0;
    logic [3:0] en_wdata = '0;
    logic       rd_clr = 0;
    logic [7:0] status_byte;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stat_irq_unit dut (
        .clk(clk), .rst_n(rst_n),
        .carry_evt(carry_evt), .borrow_evt(borrow_evt),
        .cmp_evt(cmp_evt), .idx_evt(idx_evt),
        .cnt_en(cnt_en), .dir_up(dir_up), .sign_in(sign_in),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .rd_clr(rd_clr), .status_byte(status_byte), .irq_n(irq_n)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive event vector {carry,borrow,cmp,idx} for one cycle
    task automatic pulse(input logic [3:0] ev);
        {carry_evt, borrow_evt, cmp_evt, idx_evt} = ev;
        @(negedge clk);
        {carry_evt, borrow_evt, cmp_evt, idx_evt} = 4'b0;
    endtask

    task automatic do_read(output logic [7:0] b);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        b = status_byte;
    endtask

    task automatic set_en(input logic [3:0] v);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk8("R9 status after reset", status_byte, 8'h00);
        chk1("R9 irq_n after reset", irq_n, 1'b1);
    endtask

    task automatic t_power_loss;
        logic [7:0] b;
        do_read(b);
        chk8("R3 first read shows power-loss", b, 8'h04);
        do_read(b);
        chk8("R3 second read power-loss cleared", b, 8'h00);
    endtask

    task automatic t_single_events;
        logic [7:0] b;
        pulse(4'b1000); do_read(b); chk8("R1 carry at bit7", b, 8'h80);
        do_read(b);                 chk8("R4 carry cleared by read", b, 8'h00);
        pulse(4'b0100); do_read(b); chk8("R1 borrow at bit6", b, 8'h40);
        pulse(4'b0010); do_read(b); chk8("R1 compare at bit5", b, 8'h20);
        pulse(4'b0001);
        repeat (4) @(negedge clk);
        do_read(b);                 chk8("R1 index sticky at bit4", b, 8'h10);
    endtask

    task automatic t_multi;
        logic [7:0] b;
        pulse(4'b0101);
        pulse(4'b1000);
        do_read(b); chk8("R8 several latches together", b, 8'hD0);
        do_read(b); chk8("R4 all latches cleared", b, 8'h00);
    endtask

    task automatic t_live;
        logic [7:0] b;
        cnt_en = 1; dir_up = 1; sign_in = 1;
        do_read(b); chk8("R2 live bits all one", b, 8'h0B);
        cnt_en = 1; dir_up = 0; sign_in = 0;
        do_read(b); chk8("R2 live count-enable only", b, 8'h08);
        cnt_en = 0; dir_up = 1;
        do_read(b); chk8("R2 live direction only", b, 8'h02);
        dir_up = 0;
    endtask

    task automatic t_irq;
        logic [7:0] b;
        pulse(4'b1000);
        chk1("R6 disabled source keeps irq_n high", irq_n, 1'b1);
        do_read(b); chk8("R6 disabled source still latched", b, 8'h80);
        set_en(4'b1000);
        chk1("R6 enable write alone no interrupt", irq_n, 1'b1);
        pulse(4'b0100);
        chk1("R6 borrow not enabled", irq_n, 1'b1);
        pulse(4'b1000);
        chk1("R5 irq_n low after enabled carry", irq_n, 1'b0);
        repeat (5) @(negedge clk);
        chk1("R5 irq_n stays low", irq_n, 1'b0);
        do_read(b);
        chk8("R5 read byte carry and borrow", b, 8'hC0);
        chk1("R5 irq_n released by read", irq_n, 1'b1);
    endtask

    task automatic t_same_cycle;
        logic [7:0] b;
        set_en(4'b0001);
        idx_evt = 1'b1; rd_clr = 1'b1;
        @(negedge clk);
        idx_evt = 1'b0; rd_clr = 1'b0;
        b = status_byte;
        chk8("R7 coincident event not in this read", b, 8'h00);
        chk1("R7 coincident event keeps irq_n low", irq_n, 1'b0);
        do_read(b);
        chk8("R7 coincident event in next read", b, 8'h10);
        chk1("R5 irq_n high after clearing read", irq_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_power_loss;
        t_single_events;
        t_multi;
        t_live;
        t_irq;
        t_same_cycle;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule